// File: doc/BRIEF.md
# Fully Associative Byte Cache with Selectable Write Policy

This block is a very small data cache between a byte-wide load/store port and a slower backing memory that moves one word per request/acknowledge beat. With the default parameters it holds two lines of two words each. Any block may sit in any line: the tag is the whole address above the word offset. A miss brings in the whole block. When a line has to be replaced, the line used least recently is chosen.

The write policy is fixed when the block is elaborated. In write-through mode every store also writes its single word to memory, and a line is never dirty. In write-back mode stores stay in the cache and mark the line dirty. A dirty line goes back to memory as a whole block when it is evicted or when a flush is requested. Both modes allocate on a store miss.

A flush request writes every dirty line back and then invalidates the whole cache. Four counters report hits, misses, memory word reads and memory word writes, so the traffic can be compared against a reference model.

Top module: `fa_policy_cache`

## Requirements
- R1: An address is split into tag = `cpu_addr[3:1]` and word offset = `cpu_addr[0]`. A block can be held in either of the two lines. A load that hits returns the addressed word on `cpu_rdata` with `cpu_ready` exactly one cycle after the request is accepted, and `hit_cnt` increments.
- R2: After reset no line is valid, every counter is 0, `cpu_ready` and `mem_req` are 0, and the first victim is line 0.
- R3: Every miss, load or store, increments `miss_cnt` and reads both words of the block from memory, offset 0 first and then offset 1, adding 2 to `mem_rd_cnt`.
- R4: The victim of a miss is the least recently used line. A hit or a fill makes the touched line the most recently used.
- R5: A store miss first fills the block and then merges the store word into it, and a later load of that address returns the stored word.
- R6: In write-through mode (`WRITE_BACK`=0) every store, hit or miss, writes exactly its one word to memory at its address. An eviction or a flush writes nothing to memory.
- R7: In write-back mode a store, hit or miss, writes nothing to memory and marks the line dirty. Evicting a clean line writes nothing.
- R8: In write-back mode, evicting a dirty line first writes both of its words back at the old tag (offset 0, then offset 1) and only then starts the fill of the new block.
- R9: A flush request writes back every dirty line (write-back mode only), invalidates all lines and answers with a one-cycle `flush_ack`. The next access to any previously cached address is a miss.
- R10: `cpu_ready` is a single-cycle pulse that completes each access. Loads return their data in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 4 | Byte address (tag and word offset) |
| cpu_wdata | input | 8 | Store data |
| cpu_rdata | output | 8 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| flush_req | input | 1 | Flush request, held until `flush_ack` |
| flush_ack | output | 1 | One-cycle flush completion pulse |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | 4 | Memory word address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle beat acknowledge |
| hit_cnt | output | 16 | Number of hits |
| miss_cnt | output | 16 | Number of misses |
| mem_rd_cnt | output | 16 | Memory words read |
| mem_wr_cnt | output | 16 | Memory words written |

## Verification
A single access sequence is driven into a write-back instance and a write-through instance. It mixes cold load misses, load hits, store hits, store misses, evictions of a clean victim and of a dirty victim, and a flush. The two instances must return the same load data, but their memory write counts and memory contents must differ in the expected places. A store hit on a block that is later reloaded from memory shows whether the write reached memory through the store itself or through a write-back. The order of the memory beats recorded during the dirty eviction shows whether the write-back completes before the fill starts. Hitting the line that was not chosen as victim, after a miss, confirms that replacement follows the least recently used line.

// File: rtl/fa_policy_pkg.sv
package fa_policy_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_DONE,
    ST_WTW,
    ST_FLCHK
  } ctrl_state_e;

endpackage

// File: rtl/fa_cache_lru.sv
module fa_cache_lru #(
  parameter int LINES = 2,
  parameter int WAY_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim
);

  localparam int RK_W = WAY_W;

  logic [RK_W-1:0] rank [LINES];
  logic [LINES-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) rank[i] <= RK_W'(LINES - 1 - i);
    end else if (touch_en) begin
      for (int i = 0; i < LINES; i++) begin
        if (WAY_W'(i) == touch_way)       rank[i] <= '0;
        else if (rank[i] < rank[touch_way]) rank[i] <= rank[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < LINES; i++)
      if (rank[i] == RK_W'(LINES - 1)) victim = WAY_W'(i);
  end

  always_comb begin
    seen = '0;
    for (int i = 0; i < LINES; i++) seen[rank[i]] = 1'b1;
  end

  AST_RANK_PERM: assert property (@(posedge clk) disable iff (rst)
    &seen) else $error("LRU ranks are not a permutation"); // R4

endmodule

// File: rtl/fa_cache_tags.sv
module fa_cache_tags #(
  parameter int LINES      = 2,
  parameter int WAY_W      = 1,
  parameter int TAG_W      = 3,
  parameter int WRITE_BACK = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [TAG_W-1:0]            lk_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic [LINES-1:0]            valid_v,
  output logic [LINES-1:0]            dirty_v,
  output logic [LINES-1:0][TAG_W-1:0] tags_v,
  input  logic                        fill_en,
  input  logic [WAY_W-1:0]            fill_way,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic                        fill_dirty,
  input  logic                        dirty_en,
  input  logic [WAY_W-1:0]            dirty_way,
  input  logic                        inval_en,
  input  logic [WAY_W-1:0]            inval_way
);

  logic [LINES-1:0] hit_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_v <= '0;
      dirty_v <= '0;
      tags_v  <= '0;
    end else begin
      if (inval_en) begin
        valid_v[inval_way] <= 1'b0;
        dirty_v[inval_way] <= 1'b0;
      end
      if (fill_en) begin
        valid_v[fill_way] <= 1'b1;
        dirty_v[fill_way] <= fill_dirty;
        tags_v[fill_way]  <= fill_tag;
      end
      if (dirty_en) dirty_v[dirty_way] <= 1'b1;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_v[g] = valid_v[g] && (tags_v[g] == lk_tag);
  end

  assign hit = |hit_v;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < LINES; i++)
      if (hit_v[i]) hit_way = WAY_W'(i);
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_v)) else $error("tag held by two lines"); // R1

  if (WRITE_BACK == 0) begin : g_wt_chk
    AST_WT_CLEAN: assert property (@(posedge clk) disable iff (rst)
      dirty_v == '0) else $error("dirty line in write-through mode"); // R6
  end

endmodule

// File: rtl/fa_cache_data.sv
module fa_cache_data #(
  parameter int WAY_W  = 1,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [WAY_W-1:0]  rd_way,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data
);

  localparam int IDX_W = WAY_W + OFF_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[{wr_way, wr_off}] <= wr_data;
  end

  assign rd_data = store[{rd_way, rd_off}];

endmodule

// File: rtl/fa_cache_ctrl.sv
module fa_cache_ctrl
  import fa_policy_pkg::*;
#(
  parameter int LINES      = 2,
  parameter int WAY_W      = 1,
  parameter int TAG_W      = 3,
  parameter int OFF_W      = 1,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16,
  parameter int WRITE_BACK = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cpu_req,
  input  logic                        cpu_we,
  input  logic [TAG_W+OFF_W-1:0]      cpu_addr,
  input  logic [DATA_W-1:0]           cpu_wdata,
  output logic [DATA_W-1:0]           cpu_rdata,
  output logic                        cpu_ready,
  input  logic                        flush_req,
  output logic                        flush_ack,
  output logic                        mem_req,
  output logic                        mem_we,
  output logic [TAG_W+OFF_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]           mem_wdata,
  input  logic [DATA_W-1:0]           mem_rdata,
  input  logic                        mem_ack,
  output logic [CNT_W-1:0]            hit_cnt,
  output logic [CNT_W-1:0]            miss_cnt,
  output logic [CNT_W-1:0]            mem_rd_cnt,
  output logic [CNT_W-1:0]            mem_wr_cnt,
  input  logic                        hit,
  input  logic [WAY_W-1:0]            hit_way,
  input  logic [LINES-1:0]            valid_v,
  input  logic [LINES-1:0]            dirty_v,
  input  logic [LINES-1:0][TAG_W-1:0] tags_v,
  input  logic [WAY_W-1:0]            victim,
  output logic                        fill_en,
  output logic [WAY_W-1:0]            fill_way,
  output logic [TAG_W-1:0]            fill_tag,
  output logic                        fill_dirty,
  output logic                        dirty_en,
  output logic [WAY_W-1:0]            dirty_way,
  output logic                        inval_en,
  output logic [WAY_W-1:0]            inval_way,
  output logic                        touch_en,
  output logic [WAY_W-1:0]            touch_way,
  output logic                        dwr_en,
  output logic [WAY_W-1:0]            dwr_way,
  output logic [OFF_W-1:0]            dwr_off,
  output logic [DATA_W-1:0]           dwr_data,
  output logic [WAY_W-1:0]            drd_way,
  output logic [OFF_W-1:0]            drd_off,
  input  logic [DATA_W-1:0]           drd_data
);

  localparam int ADDR_W = TAG_W + OFF_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = {OFF_W{1'b1}};
  localparam logic [WAY_W-1:0] LAST_WAY  = WAY_W'(LINES - 1);
  localparam bit WB_MODE = (WRITE_BACK != 0);

  ctrl_state_e state;
  logic [WAY_W-1:0]  way_q, fidx;
  logic [TAG_W-1:0]  tag_q;
  logic [OFF_W-1:0]  off_q, beat;
  logic              we_q, flushing;
  logic [DATA_W-1:0] wd_q;

  logic [TAG_W-1:0] req_tag;
  logic [OFF_W-1:0] req_off;
  logic             vict_dirty, flush_dirty, accept;

  assign req_tag     = cpu_addr[ADDR_W-1:OFF_W];
  assign req_off     = cpu_addr[OFF_W-1:0];
  assign accept      = (state == ST_IDLE) && cpu_req;
  assign vict_dirty  = WB_MODE && valid_v[victim] && dirty_v[victim];
  assign flush_dirty = WB_MODE && valid_v[fidx] && dirty_v[fidx];

  // data array ports
  always_comb begin
    drd_way = way_q;
    drd_off = off_q;
    if (state == ST_IDLE) begin
      drd_way = hit_way;
      drd_off = req_off;
    end else if (state == ST_WB) begin
      drd_off = beat;
    end
    dwr_en   = 1'b0;
    dwr_way  = way_q;
    dwr_off  = off_q;
    dwr_data = wd_q;
    if (accept && hit && cpu_we) begin
      dwr_en   = 1'b1;
      dwr_way  = hit_way;
      dwr_off  = req_off;
      dwr_data = cpu_wdata;
    end else if (state == ST_FILL && mem_ack) begin
      dwr_en   = 1'b1;
      dwr_off  = beat;
      dwr_data = mem_rdata;
    end else if (state == ST_DONE && we_q) begin
      dwr_en   = 1'b1;
    end
  end

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {tag_q, beat};
    mem_wdata = drd_data;
    unique case (state)
      ST_WB: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {tags_v[way_q], beat};
      end
      ST_FILL: mem_req = 1'b1;
      ST_WTW: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = {tag_q, off_q};
        mem_wdata = wd_q;
      end
      default: ;
    endcase
  end

  // metadata and replacement updates
  always_comb begin
    fill_en    = (state == ST_DONE);
    fill_way   = way_q;
    fill_tag   = tag_q;
    fill_dirty = WB_MODE && we_q;
    dirty_en   = WB_MODE && accept && hit && cpu_we;
    dirty_way  = hit_way;
    inval_en   = 1'b0;
    inval_way  = way_q;
    if (state == ST_FILL) inval_en = 1'b1;
    else if (state == ST_WB && mem_ack && beat == LAST_BEAT) inval_en = 1'b1;
    else if (state == ST_FLCHK && !flush_dirty) begin
      inval_en  = 1'b1;
      inval_way = fidx;
    end
    touch_en  = (accept && hit) || (state == ST_DONE);
    touch_way = (state == ST_DONE) ? way_q : hit_way;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cpu_ready  <= 1'b0;
      cpu_rdata  <= '0;
      flush_ack  <= 1'b0;
      way_q      <= '0;
      fidx       <= '0;
      tag_q      <= '0;
      off_q      <= '0;
      beat       <= '0;
      we_q       <= 1'b0;
      wd_q       <= '0;
      flushing   <= 1'b0;
      hit_cnt    <= '0;
      miss_cnt   <= '0;
      mem_rd_cnt <= '0;
      mem_wr_cnt <= '0;
    end else begin
      cpu_ready <= 1'b0;
      flush_ack <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cpu_req) begin
            tag_q <= req_tag;
            off_q <= req_off;
            we_q  <= cpu_we;
            wd_q  <= cpu_wdata;
            flushing <= 1'b0;
            if (hit) begin
              hit_cnt   <= hit_cnt + 1'b1;
              way_q     <= hit_way;
              cpu_rdata <= drd_data;
              if (!WB_MODE && cpu_we) state <= ST_WTW;
              else cpu_ready <= 1'b1;
            end else begin
              miss_cnt <= miss_cnt + 1'b1;
              way_q    <= victim;
              beat     <= '0;
              state    <= vict_dirty ? ST_WB : ST_FILL;
            end
          end else if (flush_req) begin
            fidx     <= '0;
            flushing <= 1'b1;
            state    <= ST_FLCHK;
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            mem_wr_cnt <= mem_wr_cnt + 1'b1;
            beat       <= beat + 1'b1;
            if (beat == LAST_BEAT) state <= flushing ? ST_FLCHK : ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            mem_rd_cnt <= mem_rd_cnt + 1'b1;
            beat       <= beat + 1'b1;
            if (beat == LAST_BEAT) state <= ST_DONE;
          end
        end
        ST_DONE: begin
          cpu_rdata <= drd_data;
          if (!WB_MODE && we_q) state <= ST_WTW;
          else begin
            cpu_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_WTW: begin
          if (mem_ack) begin
            mem_wr_cnt <= mem_wr_cnt + 1'b1;
            cpu_ready  <= 1'b1;
            state      <= ST_IDLE;
          end
        end
        ST_FLCHK: begin
          if (flush_dirty) begin
            way_q <= fidx;
            beat  <= '0;
            state <= ST_WB;
          end else if (fidx == LAST_WAY) begin
            flush_ack <= 1'b1;
            flushing  <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            fidx <= fidx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready) else $error("ready longer than one cycle"); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
    else $error("memory beat dropped before acknowledge"); // R3

  AST_WT_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!WB_MODE && mem_req && mem_we) |-> (we_q && !flushing))
    else $error("write-through memory write not caused by a store"); // R6

  AST_FLUSH_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
    flush_ack |-> !cpu_ready) else $error("flush and access completed together"); // R9

endmodule

// File: rtl/fa_policy_cache.sv
module fa_policy_cache #(
  parameter int LINES      = 2,
  parameter int TAG_W      = 3,
  parameter int OFF_W      = 1,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16,
  parameter int WRITE_BACK = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [TAG_W+OFF_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_ready,
  input  logic                    flush_req,
  output logic                    flush_ack,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [TAG_W+OFF_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  input  logic                    mem_ack,
  output logic [CNT_W-1:0]        hit_cnt,
  output logic [CNT_W-1:0]        miss_cnt,
  output logic [CNT_W-1:0]        mem_rd_cnt,
  output logic [CNT_W-1:0]        mem_wr_cnt
);

  localparam int ADDR_W = TAG_W + OFF_W;
  localparam int WAY_W  = (LINES > 1) ? $clog2(LINES) : 1;

  logic                        hit;
  logic [WAY_W-1:0]            hit_way, victim;
  logic [LINES-1:0]            valid_v, dirty_v;
  logic [LINES-1:0][TAG_W-1:0] tags_v;
  logic                        fill_en, fill_dirty, dirty_en, inval_en, touch_en;
  logic [WAY_W-1:0]            fill_way, dirty_way, inval_way, touch_way;
  logic [TAG_W-1:0]            fill_tag;
  logic                        dwr_en;
  logic [WAY_W-1:0]            dwr_way, drd_way;
  logic [OFF_W-1:0]            dwr_off, drd_off;
  logic [DATA_W-1:0]           dwr_data, drd_data;

  fa_cache_tags #(
    .LINES(LINES), .WAY_W(WAY_W), .TAG_W(TAG_W), .WRITE_BACK(WRITE_BACK)
  ) u_tags (
    .clk(clk), .rst(rst),
    .lk_tag(cpu_addr[ADDR_W-1:OFF_W]),
    .hit(hit), .hit_way(hit_way),
    .valid_v(valid_v), .dirty_v(dirty_v), .tags_v(tags_v),
    .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag), .fill_dirty(fill_dirty),
    .dirty_en(dirty_en), .dirty_way(dirty_way),
    .inval_en(inval_en), .inval_way(inval_way)
  );

  fa_cache_lru #(.LINES(LINES), .WAY_W(WAY_W)) u_lru (
    .clk(clk), .rst(rst),
    .touch_en(touch_en), .touch_way(touch_way), .victim(victim)
  );

  fa_cache_data #(.WAY_W(WAY_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
    .clk(clk),
    .wr_en(dwr_en), .wr_way(dwr_way), .wr_off(dwr_off), .wr_data(dwr_data),
    .rd_way(drd_way), .rd_off(drd_off), .rd_data(drd_data)
  );

  fa_cache_ctrl #(
    .LINES(LINES), .WAY_W(WAY_W), .TAG_W(TAG_W), .OFF_W(OFF_W),
    .DATA_W(DATA_W), .CNT_W(CNT_W), .WRITE_BACK(WRITE_BACK)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .flush_req(flush_req), .flush_ack(flush_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .mem_rd_cnt(mem_rd_cnt), .mem_wr_cnt(mem_wr_cnt),
    .hit(hit), .hit_way(hit_way), .valid_v(valid_v), .dirty_v(dirty_v), .tags_v(tags_v),
    .victim(victim),
    .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag), .fill_dirty(fill_dirty),
    .dirty_en(dirty_en), .dirty_way(dirty_way),
    .inval_en(inval_en), .inval_way(inval_way),
    .touch_en(touch_en), .touch_way(touch_way),
    .dwr_en(dwr_en), .dwr_way(dwr_way), .dwr_off(dwr_off), .dwr_data(dwr_data),
    .drd_way(drd_way), .drd_off(drd_off), .drd_data(drd_data)
  );

endmodule

// File: tb/test_fa_policy_cache.sv
module test_fa_policy_cache;

  // index 0: write-back instance, index 1: write-through instance
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       req_s [2];
  logic       we_s  [2];
  logic [3:0] adr_s [2];
  logic [7:0] wd_s  [2];
  logic [7:0] rd_s  [2];
  logic       rdy_s [2];
  logic       fl_s  [2];
  logic       fack_s[2];
  logic       mreq_s[2];
  logic       mwe_s [2];
  logic [3:0] madr_s[2];
  logic [7:0] mwd_s [2];
  logic [7:0] mrd_s [2];
  logic       mack_s[2];
  logic [15:0] hc_s [2];
  logic [15:0] mc_s [2];
  logic [15:0] rc_s [2];
  logic [15:0] wc_s [2];

  fa_policy_cache #(.WRITE_BACK(1)) i_fa_policy_cache (
    .clk(clk), .rst(rst),
    .cpu_req(req_s[0]), .cpu_we(we_s[0]), .cpu_addr(adr_s[0]), .cpu_wdata(wd_s[0]),
    .cpu_rdata(rd_s[0]), .cpu_ready(rdy_s[0]),
    .flush_req(fl_s[0]), .flush_ack(fack_s[0]),
    .mem_req(mreq_s[0]), .mem_we(mwe_s[0]), .mem_addr(madr_s[0]), .mem_wdata(mwd_s[0]),
    .mem_rdata(mrd_s[0]), .mem_ack(mack_s[0]),
    .hit_cnt(hc_s[0]), .miss_cnt(mc_s[0]), .mem_rd_cnt(rc_s[0]), .mem_wr_cnt(wc_s[0])
  );

  fa_policy_cache #(.WRITE_BACK(0)) i_fa_policy_cache_wt (
    .clk(clk), .rst(rst),
    .cpu_req(req_s[1]), .cpu_we(we_s[1]), .cpu_addr(adr_s[1]), .cpu_wdata(wd_s[1]),
    .cpu_rdata(rd_s[1]), .cpu_ready(rdy_s[1]),
    .flush_req(fl_s[1]), .flush_ack(fack_s[1]),
    .mem_req(mreq_s[1]), .mem_we(mwe_s[1]), .mem_addr(madr_s[1]), .mem_wdata(mwd_s[1]),
    .mem_rdata(mrd_s[1]), .mem_ack(mack_s[1]),
    .hit_cnt(hc_s[1]), .miss_cnt(mc_s[1]), .mem_rd_cnt(rc_s[1]), .mem_wr_cnt(wc_s[1])
  );

  // backing memory models, two cycles of latency per beat, with an operation log
  logic [7:0] bmem  [2][16];
  int         lat   [2];
  logic       op_w  [2][64];
  logic [3:0] op_a  [2][64];
  int         op_n  [2];

  function automatic logic [7:0] iv(input int a);
    return 8'(a * 13 + 7);
  endfunction

  always @(negedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (rst) begin
        mack_s[m] = 1'b0;
        lat[m]    = 0;
      end else if (mack_s[m]) begin
        mack_s[m] = 1'b0;
      end else if (mreq_s[m]) begin
        if (lat[m] == 2) begin
          lat[m]    = 0;
          mack_s[m] = 1'b1;
          mrd_s[m]  = bmem[m][madr_s[m]];
          if (mwe_s[m]) bmem[m][madr_s[m]] = mwd_s[m];
          if (op_n[m] < 64) begin
            op_w[m][op_n[m]] = mwe_s[m];
            op_a[m][op_n[m]] = madr_s[m];
            op_n[m]++;
          end
        end else begin
          lat[m]++;
        end
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic acc(input int m, input bit w, input logic [3:0] a, input logic [7:0] d,
                     output logic [7:0] r, output int cyc);
    @(negedge clk);
    req_s[m] = 1'b1;
    we_s[m]  = w;
    adr_s[m] = a;
    wd_s[m]  = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!rdy_s[m] && cyc < 500);
    r = rd_s[m];
    req_s[m] = 1'b0;
    @(negedge clk);
    chk(rdy_s[m] == 1'b0, "R10 ready is a single pulse", int'(rdy_s[m]), 0);
  endtask

  // one access with data and counter expectations; exp_rd < 0 skips the data check
  task automatic step(input int m, input bit w, input logic [3:0] a, input logic [7:0] d,
                      input int exp_rd, input int em, input int eh, input int er,
                      input int ew, input string tag);
    logic [7:0] r;
    int cyc;
    acc(m, w, a, d, r, cyc);
    if (exp_rd >= 0) chk(int'(r) == exp_rd, {tag, " load data"}, int'(r), exp_rd);
    chk(int'(mc_s[m]) == em, {tag, " miss count"}, int'(mc_s[m]), em);
    chk(int'(hc_s[m]) == eh, {tag, " hit count"}, int'(hc_s[m]), eh);
    chk(int'(rc_s[m]) == er, {tag, " memory reads"}, int'(rc_s[m]), er);
    chk(int'(wc_s[m]) == ew, {tag, " memory writes"}, int'(wc_s[m]), ew);
  endtask

  task automatic t_reset();
    for (int m = 0; m < 2; m++) begin
      chk(rdy_s[m] == 1'b0 && mreq_s[m] == 1'b0, "R2 outputs idle after reset",
          int'(rdy_s[m]) + int'(mreq_s[m]), 0);
      chk(hc_s[m] == 0 && mc_s[m] == 0 && rc_s[m] == 0 && wc_s[m] == 0,
          "R2 counters zero after reset",
          int'(hc_s[m] + mc_s[m] + rc_s[m] + wc_s[m]), 0);
    end
  endtask

  task automatic t_cold_and_hit();
    logic [7:0] r;
    int cyc;
    for (int m = 0; m < 2; m++) begin
      step(m, 1'b0, 4'd1, 8'd0, int'(iv(1)), 1, 0, 2, 0, "R3 cold load miss");
      chk(op_n[m] == 2 && op_a[m][0] == 4'd0 && op_a[m][1] == 4'd1,
          "R3 fill reads offset 0 then 1", int'(op_a[m][0]), 0);
      acc(m, 1'b0, 4'd0, 8'd0, r, cyc);
      chk(r == iv(0), "R1 load hit data", int'(r), int'(iv(0)));
      chk(cyc == 1, "R1 load hit latency", cyc, 1);
      chk(hc_s[m] == 1, "R1 hit counted", int'(hc_s[m]), 1);
      // line 0 was first victim (R2); tag 3 goes to line 1
      step(m, 1'b0, 4'd6, 8'd0, int'(iv(6)), 2, 1, 4, 0, "R2 second miss fills line 1");
    end
  endtask

  task automatic t_store_policy();
    for (int m = 0; m < 2; m++) begin
      // store hit on tag 0
      step(m, 1'b1, 4'd0, 8'hA5, -1, 2, 2, 4, (m == 0) ? 0 : 1,
           (m == 0) ? "R7 write-back store hit" : "R6 write-through store hit");
      chk(bmem[m][0] == ((m == 0) ? iv(0) : 8'hA5),
          (m == 0) ? "R7 memory untouched by store" : "R6 memory holds stored word",
          int'(bmem[m][0]), (m == 0) ? int'(iv(0)) : 165);
      // store miss, tag 5; LRU victim is clean line 1 (tag 3)
      step(m, 1'b1, 4'd11, 8'h3C, -1, 3, 2, 6, (m == 0) ? 0 : 2,
           (m == 0) ? "R7 clean eviction writes nothing" : "R6 store miss writes one word");
    end
  endtask

  task automatic t_dirty_evict();
    int n;
    for (int m = 0; m < 2; m++) begin
      // victim now line 0 (tag 0), dirty in write-back mode
      step(m, 1'b0, 4'd2, 8'd0, int'(iv(2)), 4, 2, 8, 2,
           (m == 0) ? "R8 dirty eviction" : "R6 eviction without write");
      n = op_n[m];
      if (m == 0) begin
        chk(op_w[m][n-4] && op_a[m][n-4] == 4'd0 && op_w[m][n-3] && op_a[m][n-3] == 4'd1,
            "R8 write-back of both words at old tag", int'(op_a[m][n-4]), 0);
        chk(!op_w[m][n-2] && op_a[m][n-2] == 4'd2 && !op_w[m][n-1] && op_a[m][n-1] == 4'd3,
            "R8 fill starts after write-back", int'(op_a[m][n-2]), 2);
      end
      chk(bmem[m][0] == 8'hA5, "R8 memory holds stored word", int'(bmem[m][0]), 165);
      // line 1 (tag 5) survived: LRU chose line 0
      step(m, 1'b0, 4'd10, 8'd0, int'(iv(10)), 4, 3, 8, 2, "R4 other line kept");
      step(m, 1'b0, 4'd11, 8'd0, 8'h3C, 4, 4, 8, 2, "R5 store miss merged");
      // victim is line 0 (tag 1), reload tag 0 from memory
      step(m, 1'b0, 4'd0, 8'd0, 8'hA5, 5, 4, 10, 2, "R4 reload evicted block");
    end
  endtask

  task automatic t_flush();
    int cyc;
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      fl_s[m] = 1'b1;
      cyc = 0;
      do begin
        @(negedge clk);
        cyc++;
      end while (!fack_s[m] && cyc < 500);
      fl_s[m] = 1'b0;
      chk(fack_s[m] == 1'b1, "R9 flush acknowledged", int'(fack_s[m]), 1);
      @(negedge clk);
      chk(fack_s[m] == 1'b0, "R9 flush ack single cycle", int'(fack_s[m]), 0);
      chk(int'(wc_s[m]) == ((m == 0) ? 4 : 2), "R9 flush write traffic",
          int'(wc_s[m]), (m == 0) ? 4 : 2);
      chk(bmem[m][11] == 8'h3C && bmem[m][10] == iv(10), "R9 memory after flush",
          int'(bmem[m][11]), 60);
      step(m, 1'b0, 4'd11, 8'd0, 8'h3C, 6, 4, 12, (m == 0) ? 4 : 2, "R9 miss after flush");
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      req_s[m] = 1'b0;
      we_s[m]  = 1'b0;
      adr_s[m] = '0;
      wd_s[m]  = '0;
      fl_s[m]  = 1'b0;
      mrd_s[m] = '0;
      op_n[m]  = 0;
      for (int a = 0; a < 16; a++) bmem[m][a] = iv(a);
    end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cold_and_hit();
    t_store_policy();
    t_dirty_evict();
    t_flush();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

endmodule